// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block receives two-channel PCM audio over a three-wire serial link made of a bit clock, a word clock and one data line. It turns each frame into a pair of parallel 24-bit samples, left and right, and marks each new pair with a one-cycle valid strobe. A 3-bit format code selects the framing. Left-justified and I2S framing carry 24-bit words. Right-justified framing carries 16-, 18-, 20- or 24-bit words. Two code values are reserved. Samples shorter than 24 bits come out MSB-aligned, with zeros filling the low bits.

All logic runs on one fast system clock. In slave mode an external source drives the bit clock and the word clock, and the block synchronises both of them along with the data. In master mode the block divides the system clock down to make both link clocks, drives them out, and receives data timed to them. Both modes use the same capture path, so they decode every format in exactly the same way.

Top module: `pcm_serial_rx`

## Requirements
- R1: Format code 000 (left-justified, 24 bits): data is sampled on rising bit-clock edges, MSB first. The MSB is the first bit after a word-clock transition. The left channel is carried while the word clock is high. Bits after the 24th in a slot are ignored.
- R2: Format code 001 (I2S, 24 bits): the MSB arrives one bit clock after the word-clock transition. The left channel is carried while the word clock is low. The bit at the transition and bits after the 24 data bits are ignored.
- R3: Codes 100, 101, 110 and 111 select right-justified framing with 16, 18, 20 and 24 bits. The LSB is the last bit before the next word-clock transition, and earlier bits in the slot are ignored. The left channel is carried while the word clock is high.
- R4: A word of N bits appears in the output with its MSB at bit 23, and bits 23-N down to 0 are zero. In left-justified or I2S framing, a slot too short to carry 24 bits gives its received bits at the top, with zeros below them.
- R5: While the code is 010 or 011, sample_valid stays low and both sample outputs are zero, including right after a valid format has been running.
- R6: With master_mode low, the block decodes any bit-clock ratio from 32 to 128 bit clocks per frame, and bclk_out and wclk_out stay low.
- R7: With master_mode high, bclk_out has a period of 2*BCLK_HALF system clocks. wclk_out has 64 bit-clock periods per frame, 32 of them high and 32 low. wclk_out changes only on a falling edge of bclk_out.
- R8: sample_valid is a single-cycle pulse, raised once for each frame whose left and right slots were both received complete. It is raised after the right slot ends and carries that frame's two samples. The partial slot in progress at reset produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: generate the link clocks, 0: take them from the inputs |
| fmt_code | input | 3 | Framing select (see R1 to R5) |
| bclk_in | input | 1 | Bit clock input, slave mode |
| wclk_in | input | 1 | Word clock input, slave mode |
| sdata_in | input | 1 | Serial data |
| bclk_out | output | 1 | Generated bit clock, master mode |
| wclk_out | output | 1 | Generated word clock, master mode |
| left_data | output | 24 | Left sample, MSB-aligned |
| right_data | output | 24 | Right sample, MSB-aligned |
| sample_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The hardest case to reach is a slot whose length does not match the word width. Examples are a 16-bit slot under 24-bit left-justified framing, a 24-bit slot under I2S, and a long slot under right-justified framing where the word has to be located by counting back from the next edge. The bench sweeps every legal format over slave ratios of 32, 48, 64 and 128 bit clocks per frame and fills every bit outside the data window with ones, so any misplaced window shows up as wrong data. It also follows the generated clocks in master mode, and switches to a reserved code in the middle of a stream to check that the outputs clear.

// File: rtl/pcm_serial_rx_pkg.sv
package pcm_serial_rx_pkg;

   typedef enum logic [2:0] {
      FMT_LJ24  = 3'b000,
      FMT_I2S24 = 3'b001,
      FMT_RSV0  = 3'b010,
      FMT_RSV1  = 3'b011,
      FMT_RJ16  = 3'b100,
      FMT_RJ18  = 3'b101,
      FMT_RJ20  = 3'b110,
      FMT_RJ24  = 3'b111
   } rx_fmt_e;

   function automatic logic fmt_reserved(input logic [2:0] f);
      return f[2:1] == 2'b01;
   endfunction

   function automatic logic fmt_is_rj(input logic [2:0] f);
      return f[2];
   endfunction

   function automatic int fmt_bits(input logic [2:0] f);
      case (f)
         FMT_RJ16: return 16;
         FMT_RJ18: return 18;
         FMT_RJ20: return 20;
         default:  return 24;
      endcase
   endfunction

   function automatic int fmt_offset(input logic [2:0] f);
      return (f == FMT_I2S24) ? 1 : 0;
   endfunction

   function automatic logic fmt_left_level(input logic [2:0] f);
      return (f == FMT_I2S24) ? 1'b0 : 1'b1;
   endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen #(
   parameter int HALF       = 2,
   parameter int FRAME_BITS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic bclk,
   output logic wclk
);
   localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int BW = $clog2(FRAME_BITS);

   logic [DW-1:0] divcnt;
   logic [BW-1:0] falls;
   logic [BW-1:0] falls_n;

   assign falls_n = falls + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         divcnt <= '0;
         falls  <= '0;
         bclk   <= 1'b0;
         wclk   <= 1'b0;
      end else if (divcnt == DW'(HALF - 1)) begin
         divcnt <= '0;
         bclk   <= ~bclk;
         if (bclk) begin
            falls <= falls_n;
            wclk  <= falls_n[BW-1];
         end
      end else begin
         divcnt <= divcnt + 1'b1;
      end
   end
endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
   import pcm_serial_rx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int MAX_SLOT = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt,
   input  logic                b,
   input  logic                w,
   input  logic                d,
   output logic [SAMPLE_W-1:0] left_q,
   output logic [SAMPLE_W-1:0] right_q,
   output logic                valid_q
);
   localparam int CW = $clog2(MAX_SLOT + 1);

   logic                b_q, w_q, primed, seen, have_l;
   logic [CW-1:0]       cnt;
   logic [SAMPLE_W-1:0] sh, acc, hold_l;

   logic                rise, wedge, left_ended, reserved;
   logic [CW-1:0]       idx;
   logic [SAMPLE_W-1:0] acc_n, word;
   int                  off, nbits;

   always_comb begin
      reserved   = fmt_reserved(fmt);
      off        = fmt_offset(fmt);
      nbits      = fmt_bits(fmt);
      rise       = b & ~b_q;
      wedge      = primed & (w ^ w_q);
      idx        = wedge ? '0 : cnt;
      left_ended = (w_q == fmt_left_level(fmt));
      acc_n      = wedge ? '0 : acc;
      for (int i = 0; i < SAMPLE_W; i++) begin
         if (int'(idx) == i + off) acc_n[SAMPLE_W-1-i] = d;
      end
      word = fmt_is_rj(fmt) ? (sh << (SAMPLE_W - nbits)) : acc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_q <= 1'b0; w_q <= 1'b0; primed <= 1'b0; seen <= 1'b0; have_l <= 1'b0;
         cnt <= '0; sh <= '0; acc <= '0; hold_l <= '0;
         left_q <= '0; right_q <= '0; valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         b_q     <= b;
         if (reserved) begin
            left_q  <= '0;
            right_q <= '0;
            primed  <= 1'b0;
            seen    <= 1'b0;
            have_l  <= 1'b0;
         end else if (rise) begin
            primed <= 1'b1;
            w_q    <= w;
            sh     <= {sh[SAMPLE_W-2:0], d};
            acc    <= acc_n;
            if (wedge) begin
               cnt  <= CW'(1);
               seen <= 1'b1;
               if (seen) begin
                  if (left_ended) begin
                     hold_l <= word;
                     have_l <= 1'b1;
                  end else if (have_l) begin
                     left_q  <= hold_l;
                     right_q <= word;
                     valid_q <= 1'b1;
                     have_l  <= 1'b0;
                  end
               end
            end else if (cnt != CW'(MAX_SLOT)) begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcm_serial_rx_pkg::*;
#(
   parameter int SAMPLE_W       = 24,
   parameter int MAX_SLOT       = 64,
   parameter int SYNC_STAGES    = 2,
   parameter int BCLK_HALF      = 2,
   parameter int MASTER_CAPABLE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                master_mode,
   input  logic [2:0]          fmt_code,
   input  logic                bclk_in,
   input  logic                wclk_in,
   input  logic                sdata_in,
   output logic                bclk_out,
   output logic                wclk_out,
   output logic [SAMPLE_W-1:0] left_data,
   output logic [SAMPLE_W-1:0] right_data,
   output logic                sample_valid
);
   localparam int FRAME_BITS = 64;

   if (SAMPLE_W != 24) begin : g_bad_width
      $error("SAMPLE_W must be 24");
   end
   if (BCLK_HALF < 2) begin : g_bad_half
      $error("BCLK_HALF must be at least 2");
   end
   if (MAX_SLOT < SAMPLE_W + 1) begin : g_bad_slot
      $error("MAX_SLOT too small");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic       gen_b, gen_w;
   logic [2:0] link_raw, link_s;

   if (MASTER_CAPABLE != 0) begin : g_master
      pcm_rx_clkgen #(.HALF(BCLK_HALF), .FRAME_BITS(FRAME_BITS)) u_gen (
         .clk(clk), .rst_n(rst_n), .en(master_mode), .bclk(gen_b), .wclk(gen_w)
      );
      assign link_raw = master_mode ? {gen_b, gen_w, sdata_in}
                                    : {bclk_in, wclk_in, sdata_in};
   end else begin : g_slave_only
      assign gen_b    = 1'b0;
      assign gen_w    = 1'b0;
      assign link_raw = {bclk_in, wclk_in, sdata_in};
   end

   assign bclk_out = gen_b;
   assign wclk_out = gen_w;

   pcm_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(link_raw), .dout(link_s)
   );

   pcm_rx_capture #(.SAMPLE_W(SAMPLE_W), .MAX_SLOT(MAX_SLOT)) u_cap (
      .clk(clk), .rst_n(rst_n), .fmt(fmt_code),
      .b(link_s[2]), .w(link_s[1]), .d(link_s[0]),
      .left_q(left_data), .right_q(right_data), .valid_q(sample_valid)
   );
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic                master_mode,
   input logic [2:0]          fmt_code,
   input logic                bclk_out,
   input logic                wclk_out,
   input logic [SAMPLE_W-1:0] left_data,
   input logic [SAMPLE_W-1:0] right_data,
   input logic                sample_valid
);
   logic rsv;
   assign rsv = (fmt_code == 3'b010) || (fmt_code == 3'b011);

   p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsv |=> (!sample_valid && left_data == '0 && right_data == '0));

   p_valid_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> !$past(rsv));

   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   p_slave_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |=> (!bclk_out && !wclk_out));

   p_wclk_on_bfall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && $past(master_mode) && !$stable(wclk_out)) |-> $fell(bclk_out));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .fmt_code(fmt_code),
   .bclk_out(bclk_out), .wclk_out(wclk_out), .left_data(left_data),
   .right_data(right_data), .sample_valid(sample_valid)
);

// File: tb/pcm_serial_rx_test.sv
module pcm_serial_rx_test;
   localparam int HALFB = 2;
   localparam int SLAVE_HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_mode = 1'b0;
   logic [2:0] fmt_code = 3'b000;
   logic bclk_in = 1'b0, wclk_in = 1'b0, sdata_in = 1'b0;
   logic bclk_out, wclk_out, sample_valid;
   logic [23:0] left_data, right_data;

   int checks = 0, errors = 0;
   int wr = 0, rd = 0, vcount = 0;
   bit listen = 1'b0;
   logic [23:0] exp_l [0:63];
   logic [23:0] exp_r [0:63];
   logic [31:0] seed = 32'h1234_5678;
   string tag = "R1";

   always #2.5 clk = ~clk;

   pcm_serial_rx #(.BCLK_HALF(HALFB)) uut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .fmt_code(fmt_code),
      .bclk_in(bclk_in), .wclk_in(wclk_in), .sdata_in(sdata_in),
      .bclk_out(bclk_out), .wclk_out(wclk_out), .left_data(left_data),
      .right_data(right_data), .sample_valid(sample_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] rnd24();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[31:8];
   endfunction

   function automatic logic left_lvl(input logic [2:0] f);
      return (f == 3'b001) ? 1'b0 : 1'b1;
   endfunction

   function automatic int nbits_of(input logic [2:0] f);
      case (f)
         3'b100: return 16;
         3'b101: return 18;
         3'b110: return 20;
         default: return 24;
      endcase
   endfunction

   // bit j of an H-bit slot carrying word w; positions outside the data are ones
   function automatic logic tx_bit(input logic [2:0] f, input logic [23:0] w,
                                   input int h, input int j);
      int k, n;
      if (f == 3'b001) begin
         if (j == 0 || j > 24) return 1'b1;
         return w[24-j];
      end else if (f[2]) begin
         n = nbits_of(f);
         k = h - 1 - j;
         if (k < n) return w[24-n+k];
         return 1'b1;
      end
      if (j < 24) return w[23-j];
      return 1'b1;
   endfunction

   function automatic logic [23:0] expect_of(input logic [2:0] f, input logic [23:0] w,
                                            input int h);
      int avail, n;
      logic [23:0] ones = 24'hFFFFFF;
      if (f[2]) begin
         n = nbits_of(f);
         return w & (ones << (24 - n));
      end
      avail = (f == 3'b001) ? h - 1 : h;
      if (avail >= 24) return w;
      return w & (ones << (24 - avail));
   endfunction

   always @(negedge clk) begin
      if (rst_n && sample_valid) begin
         vcount++;
         if (listen) begin
            if (rd < wr) begin
               check(left_data == exp_l[rd % 64], tag, "left sample", {8'h0, left_data}, {8'h0, exp_l[rd % 64]});
               check(right_data == exp_r[rd % 64], tag, "right sample", {8'h0, right_data}, {8'h0, exp_r[rd % 64]});
               rd++;
            end else begin
               check(1'b0, "R8", "valid with no complete frame", 32'd1, 32'd0);
            end
         end
      end
   end

   task automatic do_reset(input bit mm, input logic [2:0] f);
      rst_n = 1'b0;
      master_mode = mm;
      fmt_code = f;
      bclk_in = 1'b0;
      sdata_in = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic slave_bit(input logic lvl, input logic d);
      bclk_in = 1'b0;
      wclk_in = lvl;
      sdata_in = d;
      repeat (SLAVE_HALF) @(negedge clk);
      bclk_in = 1'b1;
      repeat (SLAVE_HALF) @(negedge clk);
   endtask

   task automatic slave_burst(input logic [2:0] f, input int h, input int frames,
                              input bit rst_first, input string req);
      logic [23:0] wl, wrt;
      logic lv;
      bit rsv;
      int start_wr;
      rsv = (f == 3'b010) || (f == 3'b011);
      if (rst_first) do_reset(1'b0, f);
      else fmt_code = f;
      tag = req;
      listen = !rsv;
      lv = left_lvl(f);
      start_wr = wr;
      for (int j = 0; j < h; j++) slave_bit(~lv, 1'b1);
      for (int fr = 0; fr < frames; fr++) begin
         wl = rnd24();
         wrt = rnd24();
         if (!rsv) begin
            exp_l[wr % 64] = expect_of(f, wl, h);
            exp_r[wr % 64] = expect_of(f, wrt, h);
            wr++;
         end
         for (int j = 0; j < h; j++) slave_bit(lv, tx_bit(f, wl, h, j));
         for (int j = 0; j < h; j++) slave_bit(~lv, tx_bit(f, wrt, h, j));
      end
      for (int j = 0; j < h; j++) slave_bit(lv, 1'b1);
      repeat (8) @(negedge clk);
      listen = 1'b0;
      if (!rsv)
         check(rd == wr, req, "pairs delivered", rd - (wr - frames), wr - start_wr);
      check(!bclk_out && !wclk_out, "R6", "clock outputs low in slave mode",
            {30'd0, bclk_out, wclk_out}, 32'd0);
   endtask

   task automatic wait_bfall();
      logic p;
      p = bclk_out;
      @(negedge clk);
      while (!(p && !bclk_out)) begin
         p = bclk_out;
         @(negedge clk);
      end
   endtask

   task automatic master_burst(input logic [2:0] f, input int frames, input string req);
      logic [23:0] w;
      logic lv, lw;
      bit found;
      int base;
      do_reset(1'b1, f);
      tag = req;
      listen = 1'b0;
      lv = left_lvl(f);
      base = wr;
      lw = wclk_out;
      found = 1'b0;
      while (!found) begin
         wait_bfall();
         found = (wclk_out == lv) && (lw != lv);
         lw = wclk_out;
      end
      for (int fr = 0; fr < frames; fr++) begin
         exp_l[wr % 64] = 24'h0;
         exp_r[wr % 64] = 24'h0;
         for (int s = 0; s < 2; s++) begin
            w = rnd24();
            if (s == 0) exp_l[wr % 64] = expect_of(f, w, 32);
            else        exp_r[wr % 64] = expect_of(f, w, 32);
            for (int j = 0; j < 32; j++) begin
               if (!(fr == 0 && s == 0 && j == 0)) wait_bfall();
               sdata_in = tx_bit(f, w, 32, j);
               if (fr == 0 && s == 0 && j == 4) listen = 1'b1;
            end
         end
         wr++;
      end
      wait_bfall();
      repeat (12) @(negedge clk);
      listen = 1'b0;
      check(rd == wr, req, "master pairs delivered", rd, wr);
      rd = wr;
   endtask

   task automatic master_clock_check();
      int since_rise, rises_seg, segs, prev_rise_gap;
      logic pb, pw;
      bit per_ok, seg_ok, edge_ok;
      do_reset(1'b1, 3'b000);
      per_ok = 1'b1; seg_ok = 1'b1; edge_ok = 1'b1;
      since_rise = -1; rises_seg = 0; segs = 0; prev_rise_gap = 0;
      pb = bclk_out; pw = wclk_out;
      for (int c = 0; c < 1500; c++) begin
         @(negedge clk);
         if (since_rise >= 0) since_rise++;
         if (!pb && bclk_out) begin
            if (since_rise >= 0 && since_rise != 2 * HALFB) begin
               per_ok = 1'b0; prev_rise_gap = since_rise;
            end
            since_rise = 0;
            rises_seg++;
         end
         if (pw != wclk_out) begin
            if (!(pb && !bclk_out)) edge_ok = 1'b0;
            if (segs > 0 && rises_seg != 32) seg_ok = 1'b0;
            segs++;
            rises_seg = 0;
         end
         pb = bclk_out; pw = wclk_out;
      end
      check(per_ok, "R7", "bit clock period", prev_rise_gap, 2 * HALFB);
      check(seg_ok, "R7", "bit clocks per word-clock half", 0, 32);
      check(edge_ok, "R7", "word clock moves on bit clock fall", 0, 1);
      check(segs >= 4, "R7", "word clock toggles", segs, 4);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int vbefore;
      do_reset(1'b0, 3'b000);
      @(negedge clk);
      check(!sample_valid && left_data == 0 && right_data == 0, "R8", "reset state",
            {7'd0, sample_valid, left_data}, 32'd0);

      // R1 left-justified at several slave ratios (R6)
      slave_burst(3'b000, 32, 4, 1'b1, "R1");
      slave_burst(3'b000, 64, 3, 1'b1, "R1");
      slave_burst(3'b000, 16, 4, 1'b1, "R4");
      // R2 I2S, including a slot too short for 24 bits (R4)
      slave_burst(3'b001, 32, 4, 1'b1, "R2");
      slave_burst(3'b001, 24, 4, 1'b1, "R4");
      slave_burst(3'b001, 16, 3, 1'b1, "R2");
      // R3 right-justified at every width
      slave_burst(3'b100, 16, 4, 1'b1, "R3");
      slave_burst(3'b101, 32, 3, 1'b1, "R3");
      slave_burst(3'b110, 64, 3, 1'b1, "R3");
      slave_burst(3'b111, 24, 3, 1'b1, "R3");
      slave_burst(3'b111, 32, 3, 1'b1, "R3");
      slave_burst(3'b100, 64, 3, 1'b1, "R4");

      // R5 switch to reserved codes mid-stream
      for (int r = 2; r < 4; r++) begin
         slave_burst(3'b000, 32, 2, 1'b1, "R1");
         vbefore = vcount;
         slave_burst(3'(r), 32, 3, 1'b0, "R5");
         check(vcount == vbefore, "R5", "no strobe on reserved code", vcount - vbefore, 0);
         check(left_data == 0 && right_data == 0, "R5", "outputs zero on reserved code",
               {8'd0, left_data | right_data}, 32'd0);
      end

      // R7 master clocks and master reception
      master_clock_check();
      master_burst(3'b001, 3, "R7");
      master_burst(3'b000, 3, "R7");
      master_burst(3'b110, 3, "R7");

      finish_run();
   end
endmodule